// File: doc/BRIEF.md
# BT Host Register and Buffer Port

This block is the host-facing register window of a block-transfer system management interface. The host sees three byte-wide registers: a control and status register, a data port into the message buffers, and an interrupt mask register. The host streams request bytes through the data port. It then raises a control bit that hands the request to the management controller side, which sees a one-cycle request-ready pulse and the request length.

The management controller fills the response buffer through its own write port. It then pulses a response-ready strobe carrying the response length. That strobe rearms the host read pointer, drops the controller-busy flag and raises the host attention flag. The host drains the response through the same data port.

The control register mixes three kinds of write action in one byte. Some bits clear a flag, one bit toggles a flag, one bit triggers the hand-over, and two bits reset buffer pointers. Neither buffer pointer wraps. Decoding of message contents and interrupt signalling belong to other blocks; the mask register only holds its two bits.

Top module: `bt_host_port`

## Requirements
- R1: After reset the control register and the mask register read 0, the request length is 0 and reqReady is low.
- R2: The host address is ANDed with WINDOW-1 before decoding. Offset 0 selects control, offset 1 selects the data port and offset 2 selects the mask register. Offset 3 reads 0, writes to it change nothing, and unused bits read 0.
- R3: Control bit 3 holds B2H attention and bit 4 holds SMS attention. Writing 1 to either bit clears that flag, and writing 0 leaves it unchanged. A smsAtnSet pulse sets the SMS flag.
- R4: Writing 1 to control bit 6 toggles the host-busy flag, which reads back in bit 6.
- R5: Writing 1 to control bit 2 sets the controller-busy flag (read in bit 7). reqReady is high for exactly the cycle after that write, and reqLen always shows the current request length.
- R6: A data-port write stores the byte at index reqLen and increments the length, but only while the length is below BUF_DEPTH. Further bytes are dropped.
- R7: A data-port read returns the response byte at the read position and advances the position while it is below the response length. At or past the end, the read returns 0 and the position does not move.
- R8: Writing 1 to control bit 0 resets the request length to 0. Writing 1 to control bit 1 resets the response read position to 0.
- R9: A rspReady pulse loads the response length (clamped to BUF_DEPTH) and resets the read position to 0. In the same cycle it clears the controller-busy flag and sets B2H attention. These effects win over a host control write or data-port read in that cycle.
- R10: The mask register stores written bits 1:0 and reads back 0 in bits 7:2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostAddr | input | ADDR_W | Host register address |
| hostWrEn | input | 1 | Host write strobe |
| hostRdEn | input | 1 | Host read strobe (advances the data port) |
| hostWrData | input | 8 | Host write byte |
| hostRdData | output | 8 | Byte of the addressed register |
| reqReady | output | 1 | One-cycle pulse: request handed over |
| reqLen | output | LEN_W | Current request length |
| bmcReqIdx | input | IDX_W | Controller-side request buffer read index |
| bmcReqData | output | 8 | Request byte at bmcReqIdx |
| bmcRspWe | input | 1 | Controller-side response buffer write enable |
| bmcRspIdx | input | IDX_W | Response buffer write index |
| bmcRspData | input | 8 | Response byte to store |
| rspReady | input | 1 | Response complete strobe |
| rspLen | input | LEN_W | Response length loaded by rspReady |
| smsAtnSet | input | 1 | Sets the SMS attention flag |

## Verification
The response-ready strobe from the controller side can fall in the same cycle as a host access. The bench provokes two such collisions: a control write that both clears B2H attention and triggers a hand-over while rspReady pulses, and a data-port read while rspReady pulses. The behavioural model applies the response effects last. It expects B2H attention to be set, controller-busy to be clear, and the read position to be back at 0. The next control and data reads must match that model.

// File: rtl/bt_host_pkg.sv
package bt_host_pkg;
  // Register offsets after masking.
  localparam int CtrlOfs = 0;
  localparam int DataOfs = 1;
  localparam int MaskOfs = 2;

  // Control register bit positions; the host driver depends on them.
  localparam int BitClrWr  = 0;
  localparam int BitClrRd  = 1;
  localparam int BitH2bAtn = 2;
  localparam int BitB2hAtn = 3;
  localparam int BitSmsAtn = 4;
  localparam int BitHBusy  = 6;
  localparam int BitBBusy  = 7;

  // Strobes from the control side to the buffer datapath.
  typedef struct packed {
    logic clrWr;
    logic clrRd;
    logic pushByte;
    logic popByte;
    logic loadRsp;
  } bufStrobes_t;
endpackage

// File: rtl/bt_host_ctrl.sv
module bt_host_ctrl
  import bt_host_pkg::*;
#(
  parameter int WINDOW = 4,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostWrEn,
  input  logic              hostRdEn,
  input  logic [7:0]        hostWrData,
  input  logic [7:0]        bufRdData,
  input  logic              rspReady,
  input  logic              smsAtnSet,
  output logic [7:0]        hostRdData,
  output bufStrobes_t       strobes,
  output logic              reqReady
);
  localparam logic [ADDR_W-1:0] SizeMask = ADDR_W'(WINDOW - 1);

  logic [ADDR_W-1:0] ofs;
  logic ctrlWr, maskWr;
  logic b2hAtn, smsAtn, hBusy, bBusy;
  logic [1:0] maskBits;

  assign ofs    = hostAddr & SizeMask;
  assign ctrlWr = hostWrEn && (ofs == ADDR_W'(CtrlOfs));
  assign maskWr = hostWrEn && (ofs == ADDR_W'(MaskOfs));

  always_comb begin
    strobes.clrWr    = ctrlWr && hostWrData[BitClrWr];
    strobes.clrRd    = ctrlWr && hostWrData[BitClrRd];
    strobes.pushByte = hostWrEn && (ofs == ADDR_W'(DataOfs));
    strobes.popByte  = hostRdEn && (ofs == ADDR_W'(DataOfs));
    strobes.loadRsp  = rspReady;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      b2hAtn   <= 1'b0;
      smsAtn   <= 1'b0;
      hBusy    <= 1'b0;
      bBusy    <= 1'b0;
      maskBits <= '0;
      reqReady <= 1'b0;
    end else begin
      reqReady <= ctrlWr && hostWrData[BitH2bAtn];
      if (ctrlWr) begin
        if (hostWrData[BitB2hAtn]) b2hAtn <= 1'b0;
        if (hostWrData[BitSmsAtn]) smsAtn <= 1'b0;
        if (hostWrData[BitHBusy])  hBusy  <= ~hBusy;
        if (hostWrData[BitH2bAtn]) bBusy  <= 1'b1;
      end
      if (smsAtnSet) smsAtn <= 1'b1;
      // Response completion applied last so it wins any collision.
      if (rspReady) begin
        bBusy  <= 1'b0;
        b2hAtn <= 1'b1;
      end
      if (maskWr) maskBits <= hostWrData[1:0];
    end
  end

  always_comb begin
    hostRdData = 8'h00;
    if (ofs == ADDR_W'(CtrlOfs)) begin
      hostRdData[BitBBusy]  = bBusy;
      hostRdData[BitHBusy]  = hBusy;
      hostRdData[BitSmsAtn] = smsAtn;
      hostRdData[BitB2hAtn] = b2hAtn;
    end else if (ofs == ADDR_W'(DataOfs)) begin
      hostRdData = bufRdData;
    end else if (ofs == ADDR_W'(MaskOfs)) begin
      hostRdData[1:0] = maskBits;
    end
  end

  // R9: response strobe leaves attention set and controller idle.
  a_r9_rsp_sets_atn: assert property (@(posedge clk) disable iff (!rstN)
    rspReady |=> (b2hAtn && !bBusy));
  // R5: hand-over marks controller busy and pulses reqReady.
  a_r5_handover_busy: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && hostWrData[BitH2bAtn] && !rspReady) |=> (bBusy && reqReady));
  // R5: reqReady never lasts two cycles without a second trigger.
  a_r5_pulse_single: assert property (@(posedge clk) disable iff (!rstN)
    (reqReady && !(ctrlWr && hostWrData[BitH2bAtn])) |=> !reqReady);
  // R4: host-busy write flips the stored flag.
  a_r4_toggle: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && hostWrData[BitHBusy]) |=> (hBusy != $past(hBusy)));
  // R3: clearing B2H attention takes effect without a competing response.
  a_r3_b2h_clear: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && hostWrData[BitB2hAtn] && !rspReady) |=> !b2hAtn);
endmodule

// File: rtl/bt_host_buf.sv
module bt_host_buf
  import bt_host_pkg::*;
#(
  parameter int BUF_DEPTH = 64,
  parameter int LEN_W     = 7,
  parameter int IDX_W     = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  bufStrobes_t      strobes,
  input  logic [7:0]       hostWrData,
  input  logic [LEN_W-1:0] rspLen,
  input  logic [IDX_W-1:0] bmcReqIdx,
  input  logic             bmcRspWe,
  input  logic [IDX_W-1:0] bmcRspIdx,
  input  logic [7:0]       bmcRspData,
  output logic [7:0]       bufRdData,
  output logic [7:0]       bmcReqData,
  output logic [LEN_W-1:0] inLen
);
  localparam logic [LEN_W-1:0] Depth = LEN_W'(BUF_DEPTH);

  logic [7:0] inMem  [BUF_DEPTH];
  logic [7:0] outMem [BUF_DEPTH];
  logic [LEN_W-1:0] outLen, outPos;
  logic inRoom, outAvail;

  assign inRoom   = inLen < Depth;
  assign outAvail = outPos < outLen;

  always_ff @(posedge clk) begin
    if (strobes.pushByte && inRoom) inMem[inLen[IDX_W-1:0]] <= hostWrData;
    if (bmcRspWe) outMem[bmcRspIdx] <= bmcRspData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inLen  <= '0;
      outLen <= '0;
      outPos <= '0;
    end else begin
      if (strobes.pushByte && inRoom) inLen <= inLen + 1'b1;
      if (strobes.clrWr) inLen <= '0;
      if (strobes.popByte && outAvail) outPos <= outPos + 1'b1;
      if (strobes.clrRd) outPos <= '0;
      if (strobes.loadRsp) begin
        outLen <= (rspLen > Depth) ? Depth : rspLen;
        outPos <= '0;
      end
    end
  end

  assign bufRdData  = outAvail ? outMem[outPos[IDX_W-1:0]] : 8'h00;
  assign bmcReqData = inMem[bmcReqIdx];

  // R6: request length never passes the buffer size.
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    inLen <= Depth);
  // R6: a push into a full buffer is dropped.
  a_r6_full_drop: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.pushByte && !inRoom && !strobes.clrWr) |=> $stable(inLen));
  // R7: the read position stays within the response.
  a_r7_pos_bound: assert property (@(posedge clk) disable iff (!rstN)
    outPos <= outLen);
  // R9: response load rewinds the read position.
  a_r9_rewind: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadRsp |=> (outPos == '0));
endmodule

// File: rtl/bt_host_port.sv
module bt_host_port
  import bt_host_pkg::*;
#(
  parameter int BUF_DEPTH = 64,
  parameter int WINDOW    = 4,
  parameter int ADDR_W    = 4,
  localparam int LEN_W    = $clog2(BUF_DEPTH + 1),
  localparam int IDX_W    = $clog2(BUF_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostWrEn,
  input  logic              hostRdEn,
  input  logic [7:0]        hostWrData,
  output logic [7:0]        hostRdData,
  output logic              reqReady,
  output logic [LEN_W-1:0]  reqLen,
  input  logic [IDX_W-1:0]  bmcReqIdx,
  output logic [7:0]        bmcReqData,
  input  logic              bmcRspWe,
  input  logic [IDX_W-1:0]  bmcRspIdx,
  input  logic [7:0]        bmcRspData,
  input  logic              rspReady,
  input  logic [LEN_W-1:0]  rspLen,
  input  logic              smsAtnSet
);
  bufStrobes_t strobes;
  logic [7:0] bufRdData;

  bt_host_ctrl #(.WINDOW(WINDOW), .ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWrEn(hostWrEn),
    .hostRdEn(hostRdEn), .hostWrData(hostWrData), .bufRdData(bufRdData),
    .rspReady(rspReady), .smsAtnSet(smsAtnSet), .hostRdData(hostRdData),
    .strobes(strobes), .reqReady(reqReady)
  );

  bt_host_buf #(.BUF_DEPTH(BUF_DEPTH), .LEN_W(LEN_W), .IDX_W(IDX_W)) uBuf (
    .clk(clk), .rstN(rstN), .strobes(strobes), .hostWrData(hostWrData),
    .rspLen(rspLen), .bmcReqIdx(bmcReqIdx), .bmcRspWe(bmcRspWe),
    .bmcRspIdx(bmcRspIdx), .bmcRspData(bmcRspData), .bufRdData(bufRdData),
    .bmcReqData(bmcReqData), .inLen(reqLen)
  );
endmodule

// File: tb/tb_bt_host_port.sv
module tb_bt_host_port;
  localparam int Depth = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] hostAddr = '0;
  logic hostWrEn = 1'b0, hostRdEn = 1'b0;
  logic [7:0] hostWrData = '0;
  logic [7:0] hostRdData;
  logic reqReady;
  logic [6:0] reqLen;
  logic [5:0] bmcReqIdx = '0;
  logic [7:0] bmcReqData;
  logic bmcRspWe = 1'b0;
  logic [5:0] bmcRspIdx = '0;
  logic [7:0] bmcRspData = '0;
  logic rspReady = 1'b0;
  logic [6:0] rspLen = '0;
  logic smsAtnSet = 1'b0;

  int checks = 0, errors = 0;

  // Behavioural reference state.
  int mB2h = 0, mSms = 0, mHBusy = 0, mBBusy = 0, mMask = 0, mReq = 0;
  int mInLen = 0, mOutLen = 0, mOutPos = 0;
  int mInMem[Depth];
  int mOutMem[Depth];

  always #5 clk = ~clk;

  bt_host_port dut (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWrEn(hostWrEn),
    .hostRdEn(hostRdEn), .hostWrData(hostWrData), .hostRdData(hostRdData),
    .reqReady(reqReady), .reqLen(reqLen), .bmcReqIdx(bmcReqIdx),
    .bmcReqData(bmcReqData), .bmcRspWe(bmcRspWe), .bmcRspIdx(bmcRspIdx),
    .bmcRspData(bmcRspData), .rspReady(rspReady), .rspLen(rspLen),
    .smsAtnSet(smsAtnSet)
  );

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int expRead();
    int o = hostAddr & 3;
    if (o == 0) return (mBBusy << 7) | (mHBusy << 6) | (mSms << 4) | (mB2h << 3);
    if (o == 1) return (mOutPos < mOutLen) ? mOutMem[mOutPos] : 0;
    if (o == 2) return mMask;
    return 0;
  endfunction

  task automatic modelUpdate();
    int o = hostAddr & 3;
    int d = hostWrData;
    mReq = (hostWrEn && o == 0 && d[2]) ? 1 : 0;
    if (hostRdEn && o == 1 && mOutPos < mOutLen) mOutPos++;
    if (hostWrEn && o == 1 && mInLen < Depth) begin
      mInMem[mInLen] = d;
      mInLen++;
    end
    if (hostWrEn && o == 0) begin
      if (d[0]) mInLen = 0;
      if (d[1]) mOutPos = 0;
      if (d[3]) mB2h = 0;
      if (d[4]) mSms = 0;
      if (d[6]) mHBusy = 1 - mHBusy;
      if (d[2]) mBBusy = 1;
    end
    if (smsAtnSet) mSms = 1;
    if (rspReady) begin
      mBBusy = 0;
      mB2h = 1;
      mOutLen = (rspLen > Depth) ? Depth : rspLen;
      mOutPos = 0;
    end
    if (hostWrEn && o == 2) mMask = d & 3;
    if (bmcRspWe) mOutMem[bmcRspIdx] = bmcRspData;
  endtask

  // One clock: compare outputs with the model, then advance both.
  task automatic cyc(string tag);
    #1;
    check(tag, "hostRdData", hostRdData, expRead());
    check(tag, "reqReady", reqReady, mReq);
    check(tag, "reqLen", reqLen, mInLen);
    if (bmcReqIdx < mInLen) check(tag, "bmcReqData", bmcReqData, mInMem[bmcReqIdx]);
    @(posedge clk);
    modelUpdate();
    @(negedge clk);
    hostWrEn = 0; hostRdEn = 0; rspReady = 0; bmcRspWe = 0; smsAtnSet = 0;
  endtask

  task automatic wr(int a, int d, string tag);
    hostAddr = 4'(a); hostWrData = 8'(d); hostWrEn = 1; cyc(tag);
  endtask

  task automatic rd(int a, string tag);
    hostAddr = 4'(a); hostRdEn = 1; cyc(tag);
  endtask

  task automatic look(int a, string tag);
    hostAddr = 4'(a); cyc(tag);
  endtask

  task automatic fillRsp(int n, int seed);
    for (int i = 0; i < n; i++) begin
      bmcRspWe = 1; bmcRspIdx = 6'(i); bmcRspData = 8'(seed + 7 * i);
      hostAddr = 0; cyc("R9");
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    look(0, "R1"); look(2, "R1");
    // R2 masking and unmapped offset
    look(4, "R2"); look(3, "R2"); look(6, "R2");
    wr(3, 8'hFF, "R2"); look(0, "R2"); look(2, "R2");
    // R6 request bytes
    for (int i = 0; i < 5; i++) begin
      bmcReqIdx = 6'(i); wr(1, 8'h30 + i, "R6");
    end
    bmcReqIdx = 2; look(0, "R6");
    // R5 hand-over
    wr(0, 8'h04, "R5"); look(0, "R5"); look(0, "R5");
    // R9 response
    fillRsp(4, 8'h51);
    rspReady = 1; rspLen = 4; look(0, "R9"); look(0, "R9");
    // R7 drain past end
    for (int i = 0; i < 6; i++) rd(1, "R7");
    // R8 pointer clears
    wr(0, 8'h02, "R8"); rd(1, "R8"); rd(1, "R8");
    wr(0, 8'h01, "R8"); look(0, "R8");
    // R3 attention flags
    wr(0, 8'h00, "R3"); look(0, "R3");
    wr(0, 8'h08, "R3"); look(0, "R3");
    smsAtnSet = 1; look(0, "R3"); look(0, "R3");
    wr(0, 8'h00, "R3"); wr(0, 8'h10, "R3"); look(0, "R3");
    // R4 host-busy toggle
    wr(0, 8'h40, "R4"); look(0, "R4"); wr(0, 8'h40, "R4"); look(0, "R4");
    // R10 mask register
    wr(2, 8'hFF, "R10"); look(2, "R10"); wr(2, 8'h02, "R10"); look(2, "R10");
    // R6 overflow drop
    for (int i = 0; i < Depth + 3; i++) begin
      bmcReqIdx = 6'(Depth - 1); wr(1, i, "R6");
    end
    look(0, "R6");
    // R9 clamp of oversized length
    rspReady = 1; rspLen = 7'd100; look(1, "R9");
    for (int i = 0; i < 3; i++) rd(1, "R9");
    // R9 collision: control write and response in one cycle
    wr(0, 8'h40, "R9");
    hostAddr = 0; hostWrData = 8'h0C; hostWrEn = 1; rspReady = 1; rspLen = 3;
    cyc("R9"); look(0, "R9");
    // R9 collision: data-port read and response in one cycle
    rd(1, "R9"); rd(1, "R9");
    hostAddr = 1; hostRdEn = 1; rspReady = 1; rspLen = 2; cyc("R9");
    look(1, "R9"); rd(1, "R9"); rd(1, "R9"); rd(1, "R9");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule